// File: doc/BRIEF.md
# Dual-Port Mailbox Interrupt Flags

This block sits beside a shared two-port memory and watches the access stream of each port. Each port owns one reserved mailbox word near the top of the address space. When the opposite port writes that word, the owner's interrupt flag goes active. When the owner later reads its own mailbox, the flag goes inactive again. The mailbox data itself is an ordinary 16-bit word that lives in the memory array and is not stored here. The block only produces the two flags.

Both ports are sampled on one common clock. Port A's mailbox is the second-highest address (0x3FFE with the default 14-bit address). Port B's mailbox is the highest address (0x3FFF). An enable input turns the function on. When the enable is low, both flags are held inactive and the two mailbox addresses act as plain memory. The flags are active low and registered. An access sampled at one rising edge shows on the flags right after that edge.

Top module: `mbox_irq_top`

## Requirements
- R1: While reset is asserted and after it is released, with no access yet made, both a_irq_n and b_irq_n are 1 (inactive).
- R2: A port-B write (b_sel_n=0, b_rd_wr_n=0) to address 0x3FFE with irq_en=1 drives a_irq_n to 0 after that rising edge.
- R3: A port-A read (a_sel_n=0, a_rd_wr_n=1) of address 0x3FFE with irq_en=1 returns a_irq_n to 1 after that edge.
- R4: A port-A write (a_sel_n=0, a_rd_wr_n=0) to address 0x3FFF with irq_en=1 drives b_irq_n to 0 after that edge.
- R5: A port-B read (b_sel_n=0, b_rd_wr_n=1) of address 0x3FFF with irq_en=1 returns b_irq_n to 1 after that edge.
- R6: When a flag's set and clear events occur in the same cycle, the flag ends active (0).
- R7: While irq_en=0, both flags are 1 after the next edge, and mailbox writes made then leave no pending flag once irq_en returns to 1.
- R8: None of the following changes a flag: an access with the select high, a port writing its own mailbox, a port reading the other port's mailbox, or an access to any other address.
- R9: With no set or clear event, each flag keeps its value from one cycle to the next.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Common clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| irq_en | input | 1 | Mailbox interrupt function enable |
| a_sel_n | input | 1 | Port A select, active low |
| a_rd_wr_n | input | 1 | Port A direction: 1 read, 0 write |
| a_addr | input | 14 | Port A word address |
| b_sel_n | input | 1 | Port B select, active low |
| b_rd_wr_n | input | 1 | Port B direction: 1 read, 0 write |
| b_addr | input | 14 | Port B word address |
| a_irq_n | output | 1 | Port A interrupt flag, active low |
| b_irq_n | output | 1 | Port B interrupt flag, active low |

## Verification
The bench covers a write and a read of the same mailbox in the same cycle. A design that let the clear win would drop a message and leave the flag inactive. It also drives look-alike accesses: a port writing its own mailbox, a port reading the peer's mailbox, and a selected-off access to a mailbox address. A decoder that swaps the mailbox addresses, or ignores the select or the direction, would toggle a flag there. It also writes a mailbox while the function is disabled and then re-enables it. A design that keeps latching events while disabled would raise a stale interrupt at that point.

// File: rtl/mbox_irq_pkg.sv
package mbox_irq_pkg;

    // Events that act on one flag during one cycle
    typedef struct packed {
        logic set;
        logic clr;
    } flag_evt_t;

    // Registered state of one flag (1 = interrupt pending)
    typedef struct packed {
        logic pend;
    } flag_state_t;

    localparam int NPORT = 2;

endpackage

// File: rtl/mbox_port_dec.sv
module mbox_port_dec #(
    parameter int ADDR_W = 14,
    parameter logic [ADDR_W-1:0] OWN_MBOX  = '0,
    parameter logic [ADDR_W-1:0] PEER_MBOX = '1
) (
    input  logic              sel_n,
    input  logic              rd_wr_n,
    input  logic [ADDR_W-1:0] addr,
    output logic              own_rd,
    output logic              peer_wr
);

    logic active;

    always_comb begin
        active  = !sel_n;
        own_rd  = active &&  rd_wr_n && (addr == OWN_MBOX);
        peer_wr = active && !rd_wr_n && (addr == PEER_MBOX);
    end

endmodule

// File: rtl/mbox_flag.sv
module mbox_flag
    import mbox_irq_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      en,
    input  flag_evt_t evt,
    output logic      irq_n
);

    flag_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (!en) begin
            st_d.pend = 1'b0;
        end else if (evt.set) begin
            st_d.pend = 1'b1;
        end else if (evt.clr) begin
            st_d.pend = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign irq_n = !st_q.pend;

endmodule

// File: rtl/mbox_irq_top.sv
module mbox_irq_top
    import mbox_irq_pkg::*;
#(
    parameter int ADDR_W = 14
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              irq_en,
    input  logic              a_sel_n,
    input  logic              a_rd_wr_n,
    input  logic [ADDR_W-1:0] a_addr,
    input  logic              b_sel_n,
    input  logic              b_rd_wr_n,
    input  logic [ADDR_W-1:0] b_addr,
    output logic              a_irq_n,
    output logic              b_irq_n
);

    localparam logic [ADDR_W-1:0] MBOX_A = {{(ADDR_W-1){1'b1}}, 1'b0};
    localparam logic [ADDR_W-1:0] MBOX_B = {ADDR_W{1'b1}};

    logic [NPORT-1:0]  sel_n_v;
    logic [NPORT-1:0]  rw_v;
    logic [ADDR_W-1:0] addr_v [NPORT];
    logic [NPORT-1:0]  own_rd_v;
    logic [NPORT-1:0]  peer_wr_v;
    logic [NPORT-1:0]  irq_n_v;
    flag_evt_t         evt_v [NPORT];

    assign sel_n_v   = {b_sel_n, a_sel_n};
    assign rw_v      = {b_rd_wr_n, a_rd_wr_n};
    assign addr_v[0] = a_addr;
    assign addr_v[1] = b_addr;

    for (genvar p = 0; p < NPORT; p++) begin : g_port
        localparam logic [ADDR_W-1:0] OWN  = (p == 0) ? MBOX_A : MBOX_B;
        localparam logic [ADDR_W-1:0] PEER = (p == 0) ? MBOX_B : MBOX_A;

        mbox_port_dec #(
            .ADDR_W   (ADDR_W),
            .OWN_MBOX (OWN),
            .PEER_MBOX(PEER)
        ) u_dec (
            .sel_n  (sel_n_v[p]),
            .rd_wr_n(rw_v[p]),
            .addr   (addr_v[p]),
            .own_rd (own_rd_v[p]),
            .peer_wr(peer_wr_v[p])
        );

        // Flag p is set by the other port writing mailbox p
        always_comb begin
            evt_v[p].set = peer_wr_v[NPORT-1-p];
            evt_v[p].clr = own_rd_v[p];
        end

        mbox_flag u_flag (
            .clk  (clk),
            .rst_n(rst_n),
            .en   (irq_en),
            .evt  (evt_v[p]),
            .irq_n(irq_n_v[p])
        );
    end

    assign a_irq_n = irq_n_v[0];
    assign b_irq_n = irq_n_v[1];

endmodule

// File: rtl/mbox_irq_chk.sv
module mbox_irq_chk #(
    parameter int ADDR_W = 14
) (
    input logic              clk,
    input logic              rst_n,
    input logic              irq_en,
    input logic              a_sel_n,
    input logic              a_rd_wr_n,
    input logic [ADDR_W-1:0] a_addr,
    input logic              b_sel_n,
    input logic              b_rd_wr_n,
    input logic [ADDR_W-1:0] b_addr,
    input logic              a_irq_n,
    input logic              b_irq_n
);

    localparam logic [ADDR_W-1:0] BOX_A = {ADDR_W{1'b1}} - 1'b1;
    localparam logic [ADDR_W-1:0] BOX_B = {ADDR_W{1'b1}};

    logic set_a, clr_a, set_b, clr_b;
    assign set_a = !b_sel_n && !b_rd_wr_n && (b_addr == BOX_A);
    assign clr_a = !a_sel_n &&  a_rd_wr_n && (a_addr == BOX_A);
    assign set_b = !a_sel_n && !a_rd_wr_n && (a_addr == BOX_B);
    assign clr_b = !b_sel_n &&  b_rd_wr_n && (b_addr == BOX_B);

    // R1
    always @(posedge clk) begin
        if (!rst_n) begin
            a_r1_reset_idle: assert (a_irq_n && b_irq_n);
        end
    end

    a_r2_set_a: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_en && set_a) |=> !a_irq_n);
    a_r3_clr_a: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_en && clr_a && !set_a) |=> a_irq_n);
    a_r4_set_b: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_en && set_b) |=> !b_irq_n);
    a_r5_clr_b: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_en && clr_b && !set_b) |=> b_irq_n);
    a_r7_disabled: assert property (@(posedge clk) disable iff (!rst_n)
        !irq_en |=> (a_irq_n && b_irq_n));
    a_r9_hold_a: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_en && !set_a && !clr_a) |=> $stable(a_irq_n));
    a_r9_hold_b: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_en && !set_b && !clr_b) |=> $stable(b_irq_n));

endmodule

bind mbox_irq_top mbox_irq_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .irq_en   (irq_en),
    .a_sel_n  (a_sel_n),
    .a_rd_wr_n(a_rd_wr_n),
    .a_addr   (a_addr),
    .b_sel_n  (b_sel_n),
    .b_rd_wr_n(b_rd_wr_n),
    .b_addr   (b_addr),
    .a_irq_n  (a_irq_n),
    .b_irq_n  (b_irq_n)
);

// File: tb/sim_mbox_irq_top.sv
module sim_mbox_irq_top;

    localparam int CLK_PERIOD = 10;
    localparam int AW = 14;
    localparam logic [AW-1:0] BOX_A = 14'h3FFE;
    localparam logic [AW-1:0] BOX_B = 14'h3FFF;
    localparam int RND_CYCLES = 3000;
    localparam int WATCHDOG = 20000;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic irq_en = 1'b1;
    logic a_sel_n = 1'b1, a_rd_wr_n = 1'b1;
    logic b_sel_n = 1'b1, b_rd_wr_n = 1'b1;
    logic [AW-1:0] a_addr = '0, b_addr = '0;
    logic a_irq_n, b_irq_n;

    int checks = 0;
    int fails = 0;
    bit done = 1'b0;
    bit exp_a = 1'b0;  // 1 = pending (output low)
    bit exp_b = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    mbox_irq_top #(.ADDR_W(AW)) u0 (
        .clk(clk), .rst_n(rst_n), .irq_en(irq_en),
        .a_sel_n(a_sel_n), .a_rd_wr_n(a_rd_wr_n), .a_addr(a_addr),
        .b_sel_n(b_sel_n), .b_rd_wr_n(b_rd_wr_n), .b_addr(b_addr),
        .a_irq_n(a_irq_n), .b_irq_n(b_irq_n)
    );

    function automatic bit wr_hit(logic s, logic rw, logic [AW-1:0] ad, logic [AW-1:0] box);
        return !s && !rw && (ad == box);
    endfunction

    function automatic bit rd_hit(logic s, logic rw, logic [AW-1:0] ad, logic [AW-1:0] box);
        return !s && rw && (ad == box);
    endfunction

    function automatic bit next_flag(bit cur, bit en, bit set, bit clr);
        if (!en) return 1'b0;
        if (set) return 1'b1;
        if (clr) return 1'b0;
        return cur;
    endfunction

    task automatic check(string tag);
        checks++;
        if (a_irq_n !== !exp_a || b_irq_n !== !exp_b) begin
            fails++;
            $display("FAIL %s: a_irq_n=%b b_irq_n=%b expected a_irq_n=%b b_irq_n=%b",
                     tag, a_irq_n, b_irq_n, !exp_a, !exp_b);
        end
    endtask

    // Called just after a falling edge: drive, predict, wait one cycle, check
    task automatic cyc(logic en, logic as, logic arw, logic [AW-1:0] aa,
                       logic bs, logic brw, logic [AW-1:0] ba, string tag);
        irq_en = en;
        a_sel_n = as; a_rd_wr_n = arw; a_addr = aa;
        b_sel_n = bs; b_rd_wr_n = brw; b_addr = ba;
        exp_a = next_flag(exp_a, en, wr_hit(bs, brw, ba, BOX_A), rd_hit(as, arw, aa, BOX_A));
        exp_b = next_flag(exp_b, en, wr_hit(as, arw, aa, BOX_B), rd_hit(bs, brw, ba, BOX_B));
        @(negedge clk);
        check(tag);
    endtask

    task automatic idle(string tag);
        cyc(1'b1, 1'b1, 1'b1, '0, 1'b1, 1'b1, '0, tag);
    endtask

    initial begin
        void'($urandom(32'd1234));
        repeat (3) @(negedge clk);
        check("R1 during reset");
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 after reset");

        // R2 / R9
        cyc(1, 1, 1, '0, 0, 0, BOX_A, "R2 set A");
        idle("R9 hold A");
        // R8 look-alikes on flag A
        cyc(1, 0, 0, BOX_A, 0, 1, BOX_A, "R8 own write / peer read");
        cyc(1, 1, 1, BOX_A, 1, 1, '0, "R8 deselected read");
        cyc(1, 0, 1, 14'h0123, 0, 1, 14'h3FFD, "R8 other address");
        // R3
        cyc(1, 0, 1, BOX_A, 1, 1, '0, "R3 clear A");
        // R4 / R5
        cyc(1, 0, 0, BOX_B, 1, 1, '0, "R4 set B");
        cyc(1, 0, 1, BOX_B, 0, 0, BOX_B, "R8 peer read / own write B");
        cyc(1, 1, 1, '0, 1, 1, BOX_B, "R8 deselected B");
        cyc(1, 1, 1, '0, 0, 1, BOX_B, "R5 clear B");
        // R6 simultaneous set and clear
        cyc(1, 0, 1, BOX_A, 0, 0, BOX_A, "R6 A set wins");
        cyc(1, 0, 0, BOX_B, 0, 1, BOX_B, "R6 B set wins");
        // R7
        cyc(0, 1, 1, '0, 1, 1, '0, "R7 disable clears");
        cyc(0, 0, 0, BOX_B, 0, 0, BOX_A, "R7 writes while disabled");
        idle("R7 no stale flag");
        cyc(1, 0, 0, BOX_B, 0, 0, BOX_A, "R2 R4 both set");

        // Random traffic biased toward mailbox addresses
        for (int i = 0; i < RND_CYCLES; i++) begin
            logic [AW-1:0] aa, ba;
            int ra, rb;
            ra = $urandom % 4;
            rb = $urandom % 4;
            aa = (ra == 0) ? BOX_A : (ra == 1) ? BOX_B : (ra == 2) ? AW'($urandom) : 14'h3FFD;
            ba = (rb == 0) ? BOX_A : (rb == 1) ? BOX_B : (rb == 2) ? AW'($urandom) : 14'h0000;
            cyc(($urandom % 16) != 0, $urandom % 2, $urandom % 2, aa,
                $urandom % 2, $urandom % 2, ba, "R9 random mix");
        end

        if (!done) begin
            done = 1'b1;
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    initial begin
        repeat (WATCHDOG) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            checks++;
            fails++;
            $display("FAIL watchdog: run did not finish, actual timeout expected completion");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

endmodule